// File: doc/BRIEF.md
# Static Memory Burst Write Controller

This block drives the write side of an external static memory or expansion bus. A single start request launches a burst of 2 to 4 consecutive write beats to one chip select. The burst begins at a base address. Each beat takes its data from an incoming write-data stream. A pop pulse tells the producer when the current stream word has been taken. The address steps by the access size after every beat. The size, word or halfword, is shown on a size output.

Each beat lasts one clock at minimum. It is stretched in whole clocks in two ways. The first is a programmed wait count. The second is an external ready line, which is captured on the falling clock edge inside the beat's transfer cycle. Memories that capture on the write strobe need a distinct strobe pulse per beat. For them a strobe mode forces at least one wait cycle per beat, so the strobe can rise before the next beat starts. The output enable stays inactive for the whole burst.

Top module: `smem_burst_wr`

## Requirements
- R1: The requested beat count `beat_req` is clamped when a burst starts. Values 0 and 1 give 2 beats, values 5 to 7 give 4 beats, and 2 to 4 are used unchanged.
- R2: Every beat lasts 1 + E + S clock cycles. E is the effective wait count and S is the number of ready stalls. With `strobe_mode` low, E equals `wait_req`, so a 4-beat burst with `wait_req` 0 and ready high takes exactly 4 cycles.
- R3: With `strobe_mode` high, E is max(`wait_req`, 1). The wait count and the mode are latched when the burst starts.
- R4: The last cycle of a beat is its transfer cycle, and `ext_rdy` is captured on the falling clock edge inside it. A low capture repeats the transfer cycle. Ready has no effect during wait cycles.
- R5: `cs_n` is low (active) from the first cycle of the first beat through the last cycle of the final beat. It is high at all other times.
- R6: `mem_addr` shows `base_addr` during the first beat. It adds 4 after each word beat and 2 after each halfword beat, and it reads 0 while idle.
- R7: If E is 0, `we_n` is low in every cycle of the burst. If E is at least 1, `we_n` is low in wait cycles and high in transfer cycles. `mem_dq` holds the beat's data for the entire beat and reads 0 while idle.
- R8: `oe_n` is high at all times.
- R9: `half_sel` is 1 during a burst started with `word_sel` = 0 (halfword), 0 during word bursts, and 0 while idle.
- R10: `done` is high for exactly one cycle, the cycle right after the final beat's transfer completes. This is also the first cycle with `cs_n` high again.
- R11: A `start` is accepted only while no burst is active. A `start` during a burst has no effect on that burst's length, beats or data.
- R12: `data_pop` is high in a cycle exactly when `wr_data` is taken at the next rising edge. That happens on an accepted start and on completion of a non-final beat. One burst therefore pops as many words as it has beats.
- R13: While reset is held, and afterwards until a start, `cs_n`, `we_n` and `oe_n` are 1, and `done`, `data_pop`, `half_sel`, `mem_addr` and `mem_dq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge for state, falling edge for ready capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a burst |
| base_addr | input | AW | First beat address |
| beat_req | input | 3 | Requested number of beats (clamped to 2..4) |
| wait_req | input | WW | Programmed wait cycles per beat |
| word_sel | input | 1 | 1 = word beats, 0 = halfword beats |
| strobe_mode | input | 1 | 1 = memory captures on the write strobe; forces at least one wait |
| wr_data | input | DW | Head of the write-data stream |
| ext_rdy | input | 1 | External ready, captured on the falling edge |
| data_pop | output | 1 | Stream word taken at the next rising edge |
| cs_n | output | 1 | Active-low chip select |
| mem_addr | output | AW | Beat address |
| mem_dq | output | DW | Beat write data |
| we_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low output enable, held inactive |
| half_sel | output | 1 | Halfword access indicator |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
Several rules are checked by assertions on every cycle. Chip select rises only together with the done pulse, and done never lasts two cycles. A burst never holds a count outside 2..4 or a beat index past its end. Strobe mode never runs with a zero wait count. The address moves by exactly the access size at each beat change, and the data bus stays fixed inside a beat. Some behaviour only the bench scenarios can show, because it depends on the history of the inputs. This covers the exact beat length under each wait and stall combination, and the fact that ready is ignored during wait cycles. It also covers how many stream words a burst consumes, and that start requests during a burst leave it unchanged.

// File: rtl/smem_burst_pkg.sv
package smem_burst_pkg;
  localparam int BEAT_W    = 3;
  localparam int MIN_BEATS = 2;
  localparam int MAX_BEATS = 4;

  // Clamp a requested beat count into the legal burst range.
  function automatic logic [BEAT_W-1:0] clamp_beats(input logic [BEAT_W-1:0] req);
    if (int'(req) < MIN_BEATS) return BEAT_W'(MIN_BEATS);
    if (int'(req) > MAX_BEATS) return BEAT_W'(MAX_BEATS);
    return req;
  endfunction

  // Effective wait count: strobe-captured memories need at least one.
  function automatic int unsigned eff_wait(input int unsigned req, input logic strobe);
    if (strobe && req == 0) return 1;
    return req;
  endfunction

  // Address increment for one beat of the given size.
  function automatic logic [2:0] addr_step(input logic word);
    return word ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/smem_wait_timer.sv
module smem_wait_timer #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic          next_beat,
  input  logic          active,
  input  logic [WW-1:0] wait_in,
  input  logic          strobe_in,
  input  logic          ext_rdy,
  output logic          xfer_ok,
  output logic          in_wait,
  output logic          zero_wait
);
  import smem_burst_pkg::*;

  logic [WW-1:0] wl_q;
  logic [WW-1:0] weff_q;
  logic [WW-1:0] weff_new;
  logic          strobe_q;
  logic          rdy_q;

  assign weff_new = WW'(eff_wait(32'(wait_in), strobe_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q     <= '0;
      weff_q   <= '0;
      strobe_q <= 1'b0;
    end else if (start_acc) begin
      weff_q   <= weff_new;
      strobe_q <= strobe_in;
      wl_q     <= weff_new;
    end else if (next_beat) begin
      wl_q <= weff_q;
    end else if (active && wl_q != '0) begin
      wl_q <= wl_q - 1'b1;
    end
  end

  // Ready is captured mid-cycle, ahead of the transfer edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b1;
    else        rdy_q <= ext_rdy;
  end

  assign in_wait   = wl_q != '0;
  assign zero_wait = weff_q == '0;
  assign xfer_ok   = active && !in_wait && rdy_q;

  // R3
  strobe_min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe_q) |-> weff_q != '0);
endmodule

// File: rtl/smem_beat_seq.sv
module smem_beat_seq (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_acc,
  input  logic [smem_burst_pkg::BEAT_W-1:0] beat_req,
  input  logic                              xfer_ok,
  output logic                              active,
  output logic                              next_beat,
  output logic                              finish,
  output logic                              done
);
  import smem_burst_pkg::*;

  logic [BEAT_W-1:0] idx_q;
  logic [BEAT_W-1:0] total_q;
  logic              active_q;
  logic              done_q;
  logic              last;

  assign last      = idx_q == total_q - 1'b1;
  assign next_beat = xfer_ok && !last;
  assign finish    = xfer_ok && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      total_q  <= BEAT_W'(MIN_BEATS);
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_acc) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        total_q  <= clamp_beats(beat_req);
      end else if (finish) begin
        active_q <= 1'b0;
      end else if (next_beat) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active = active_q;
  assign done   = done_q;

  // R1
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (int'(total_q) >= MIN_BEATS && int'(total_q) <= MAX_BEATS && idx_q < total_q));
endmodule

// File: rtl/smem_addr_gen.sv
module smem_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_acc,
  input  logic          next_beat,
  input  logic          active,
  input  logic [AW-1:0] base_addr,
  input  logic          word_sel,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq,
  output logic          half_sel
);
  import smem_burst_pkg::*;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      word_q <= 1'b1;
    end else if (start_acc) begin
      addr_q <= base_addr;
      data_q <= wr_data;
      word_q <= word_sel;
    end else if (next_beat) begin
      addr_q <= addr_q + AW'(addr_step(word_q));
      data_q <= wr_data;
    end
  end

  assign mem_addr = active ? addr_q : '0;
  assign mem_dq   = active ? data_q : '0;
  assign half_sel = active && !word_q;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_beat |=> addr_q == $past(addr_q) + AW'(word_q ? 4 : 2));
endmodule

// File: rtl/smem_burst_wr.sv
module smem_burst_wr #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [2:0]    beat_req,
  input  logic [WW-1:0] wait_req,
  input  logic          word_sel,
  input  logic          strobe_mode,
  input  logic [DW-1:0] wr_data,
  input  logic          ext_rdy,
  output logic          data_pop,
  output logic          cs_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq,
  output logic          we_n,
  output logic          oe_n,
  output logic          half_sel,
  output logic          done
);
  logic active;
  logic start_acc;
  logic next_beat;
  logic finish;
  logic xfer_ok;
  logic in_wait;
  logic zero_wait;

  assign start_acc = start && !active;

  smem_beat_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .beat_req  (beat_req),
    .xfer_ok   (xfer_ok),
    .active    (active),
    .next_beat (next_beat),
    .finish    (finish),
    .done      (done)
  );

  smem_wait_timer #(.WW(WW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .next_beat (next_beat),
    .active    (active),
    .wait_in   (wait_req),
    .strobe_in (strobe_mode),
    .ext_rdy   (ext_rdy),
    .xfer_ok   (xfer_ok),
    .in_wait   (in_wait),
    .zero_wait (zero_wait)
  );

  smem_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .next_beat (next_beat),
    .active    (active),
    .base_addr (base_addr),
    .word_sel  (word_sel),
    .wr_data   (wr_data),
    .mem_addr  (mem_addr),
    .mem_dq    (mem_dq),
    .half_sel  (half_sel)
  );

  assign data_pop = start_acc || next_beat;
  assign cs_n     = !active;
  assign we_n     = !(active && (in_wait || zero_wait));
  assign oe_n     = 1'b1;

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !data_pop) |=> (cs_n || $stable(mem_dq)));
endmodule

// File: tb/smem_burst_wr_test.sv
module smem_burst_wr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [2:0]  beat_req = '0;
  logic [3:0]  wait_req = '0;
  logic        word_sel = 1'b1;
  logic        strobe_mode = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ext_rdy = 1'b1;
  logic        data_pop, cs_n, we_n, oe_n, half_sel, done;
  logic [31:0] mem_addr, mem_dq;

  smem_burst_wr uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .beat_req(beat_req), .wait_req(wait_req), .word_sel(word_sel),
    .strobe_mode(strobe_mode), .wr_data(wr_data), .ext_rdy(ext_rdy),
    .data_pop(data_pop), .cs_n(cs_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .we_n(we_n), .oe_n(oe_n), .half_sel(half_sel), .done(done)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  bit          m_busy = 0, m_done = 0, m_word = 1, exp_pop = 0;
  int          m_beat = 0, m_total = 2, m_wl = 0, m_weff = 0;
  logic [31:0] m_addr = '0, m_data = '0;
  int          seq = 0;

  // stimulus controls
  bit drv_start = 0, rdy_low = 0;
  int cs_cnt = 0, pop_cnt = 0, done_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic int req_to_beats(input logic [2:0] r);
    int n = int'(r);
    return (n < 2) ? 2 : ((n > 4) ? 4 : n);
  endfunction

  function automatic logic [31:0] stream_word(input int n);
    return 32'hA500_0000 + 32'(n) * 32'h0000_0111;
  endfunction

  task automatic model_update();
    m_done = 0;
    if (m_busy) begin
      if (m_wl > 0) m_wl--;
      else if (ext_rdy) begin
        if (m_beat == m_total - 1) begin
          m_busy = 0;
          m_done = 1;
        end else begin
          m_beat++;
          m_addr = m_addr + (m_word ? 32'd4 : 32'd2);
          m_data = wr_data;
          m_wl   = m_weff;
        end
      end
    end else if (start) begin
      m_busy  = 1;
      m_beat  = 0;
      m_total = req_to_beats(beat_req);
      m_addr  = base_addr;
      m_data  = wr_data;
      m_word  = word_sel;
      m_weff  = (strobe_mode && wait_req == 0) ? 1 : int'(wait_req);
      m_wl    = m_weff;
    end
    if (exp_pop) seq++;
  endtask

  task automatic compare();
    bit e_we;
    exp_pop = (start && !m_busy) || (m_busy && m_wl == 0 && ext_rdy && m_beat != m_total - 1);
    e_we = !(m_busy && (m_wl > 0 || m_weff == 0));
    check(cs_n == !m_busy, "R5 cs_n", 32'(cs_n), 32'(!m_busy));
    check(mem_addr == (m_busy ? m_addr : 32'd0), "R6 mem_addr", mem_addr, m_busy ? m_addr : 32'd0);
    check(we_n == e_we, "R7 we_n", 32'(we_n), 32'(e_we));
    check(mem_dq == (m_busy ? m_data : 32'd0), "R7 mem_dq", mem_dq, m_busy ? m_data : 32'd0);
    check(oe_n == 1'b1, "R8 oe_n", 32'(oe_n), 32'd1);
    check(half_sel == (m_busy && !m_word), "R9 half_sel", 32'(half_sel), 32'(m_busy && !m_word));
    check(done == m_done, "R10 done", 32'(done), 32'(m_done));
    check(data_pop == exp_pop, "R12 data_pop", 32'(data_pop), 32'(exp_pop));
    if (!cs_n) cs_cnt++;
    if (data_pop) pop_cnt++;
    if (done) done_cnt++;
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    model_update();
    start   = drv_start;
    ext_rdy = !rdy_low;
    wr_data = stream_word(seq);
    #6;
    compare();
  endtask

  task automatic run_burst(input logic [31:0] base, input logic [2:0] req, input logic [3:0] wt,
                           input logic word, input logic strb, input int stall_from,
                           input int stall_n, input int poke, input int exp_len, input string tag);
    base_addr = base; beat_req = req; wait_req = wt; word_sel = word; strobe_mode = strb;
    cs_cnt = 0; pop_cnt = 0; done_cnt = 0;
    rdy_low = 0;
    drv_start = 1;
    cycle();
    for (int k = 1; k < 200; k++) begin
      drv_start = (k <= poke);
      rdy_low   = (k >= stall_from && k < stall_from + stall_n);
      cycle();
      if (done_cnt > 0) break;
    end
    drv_start = 0; rdy_low = 0;
    check(cs_cnt == exp_len, tag, 32'(cs_cnt), 32'(exp_len));
    check(pop_cnt == req_to_beats(req), "R12 pops per burst", 32'(pop_cnt), 32'(req_to_beats(req)));
    check(done_cnt == 1, "R10 single done", 32'(done_cnt), 32'd1);
    cycle();
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #7;
    // R13 reset state
    check(cs_n == 1'b1 && we_n == 1'b1 && oe_n == 1'b1, "R13 strobes idle in reset",
          {29'd0, cs_n, we_n, oe_n}, 32'd7);
    check(done == 1'b0 && data_pop == 1'b0 && half_sel == 1'b0 && mem_addr == 0 && mem_dq == 0,
          "R13 outputs zero in reset", mem_addr | mem_dq, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) cycle();

    // R2: 1-1-1-1 word burst
    run_burst(32'h0000_1000, 3'd4, 4'd0, 1'b1, 1'b0, 0, 0, 0, 4, "R2 zero-wait length");
    // R2: halfword burst with two waits
    run_burst(32'h0000_2002, 3'd3, 4'd2, 1'b0, 1'b0, 0, 0, 0, 9, "R2 waited length");
    // R3: strobe mode forces one wait
    run_burst(32'h0000_3000, 3'd2, 4'd0, 1'b1, 1'b1, 0, 0, 0, 4, "R3 forced wait");
    run_burst(32'h0000_3100, 3'd3, 4'd3, 1'b0, 1'b1, 0, 0, 0, 12, "R3 larger wait kept");
    // R1: clamping
    run_burst(32'h0000_4000, 3'd0, 4'd1, 1'b1, 1'b0, 0, 0, 0, 4, "R1 clamp from 0");
    run_burst(32'h0000_4100, 3'd1, 4'd0, 1'b0, 1'b0, 0, 0, 0, 2, "R1 clamp from 1");
    run_burst(32'h0000_4200, 3'd7, 4'd0, 1'b1, 1'b0, 0, 0, 0, 4, "R1 clamp from 7");
    run_burst(32'h0000_4300, 3'd5, 4'd1, 1'b0, 1'b0, 0, 0, 0, 8, "R1 clamp from 5");
    // R4: ready stalls, zero waits: three stalls
    run_burst(32'h0000_5000, 3'd2, 4'd0, 1'b1, 1'b0, 1, 3, 0, 5, "R4 stall zero-wait");
    // R4: ready low during a wait cycle is ignored, then two stalls
    run_burst(32'h0000_5100, 3'd2, 4'd1, 1'b1, 1'b0, 1, 3, 0, 6, "R4 stall after wait");
    // R11: start held during the first cycles of a burst
    run_burst(32'h0000_6000, 3'd3, 4'd2, 1'b0, 1'b0, 0, 0, 3, 9, "R11 start while busy");
    run_burst(32'h0000_6100, 3'd4, 4'd1, 1'b1, 1'b1, 2, 2, 5, 10, "R11 start held with stalls");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule